// File: doc/BRIEF.md
# Vector length control register unit

This unit holds the two length controls of a vector-capable 64-bit integer core: the active vector length (VL) and the maximum vector length (MVL). Both are kept in six-bit registers that store the length minus one, so lengths 1 through 64 fit without a seventh bit. The limit of 64 equals the integer register width, so a predicate mask covering a full vector still fits in one integer register.

Software reaches the unit through a single-cycle control-register port. Each request carries an address, a three-bit operation code, a register write value and a five-bit immediate. The VL and MVL addresses show true lengths. A third, packed context view exposes both biased fields as they are stored, which lets a context switch save and restore them with no arithmetic. Every write is clamped so that both lengths stay between 1 and their limits, and VL never exceeds MVL. The true lengths are also driven on dedicated outputs for the vector datapath.

Top module: `vlcsr_unit`

## Requirements
- R1: After a synchronous reset both stored fields are 0, so VL and MVL read as 1 and the packed context view reads as 0.
- R2: A request at the VL or MVL address returns the true length (stored value plus one) on csr_rdata in the same cycle as the request. When the operation writes, csr_rdata shows the value from before the write, and the new value appears from the next cycle on.
- R3: The packed context view (address 0x7C0) reads MVL−1 in bits 11:6 and VL−1 in bits 5:0, with all higher bits 0. A write there loads both biased fields directly from those bit positions. If the VL field is larger than the MVL field, the VL field is stored equal to the MVL field.
- R4: A write to VL (address 0x7C1) stores the new length clamped to the range 1 to the current MVL. A value of 0 becomes 1 and a value above MVL becomes MVL.
- R5: A write to MVL (address 0x7C2) stores the new length clamped to the range 1 to 64. If the current VL is above the new MVL, VL is lowered to the new MVL in the same cycle.
- R6: The immediate write operation (code 3'b101) on VL or MVL uses the immediate as an already-biased length, so the true length written is imm+1. On the packed view it writes the zero-extended immediate unchanged.
- R7: The set-bits operations (3'b010, and 3'b110 with the zero-extended immediate) OR their operand into the current true length. The clear-bits operations (3'b011, and 3'b111 with the immediate) clear the operand's bits from the current true length. The result is then clamped as in R4 and R5.
- R8: With csr_valid low, with an address that is none of the three, or with a read-only code (3'b000 or 3'b100), the stored lengths do not change. An unknown address returns 0 on csr_rdata.
- R9: VL never exceeds MVL after any sequence of requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid | input | 1 | Request present this cycle |
| csr_addr | input | 12 | Register address: 0x7C0 packed view, 0x7C1 VL, 0x7C2 MVL |
| csr_op | input | 3 | Operation code: 000 read, 001 write, 010 set bits, 011 clear bits, 100 read, 101 write immediate, 110 set immediate, 111 clear immediate |
| csr_wdata | input | 64 | Register operand for codes 001 to 011 |
| csr_imm | input | 5 | Immediate operand for codes 101 to 111 |
| csr_rdata | output | 64 | Value before the request, same cycle |
| vl_len | output | 7 | Current true VL (1 to 64) |
| mvl_len | output | 7 | Current true MVL (1 to 64) |

## Verification
The exact-value properties for VL and MVL writes assume that csr_wdata is already in range. Their antecedents therefore exclude 0 and any value above the limit, and the clamping cases are covered by the directed checks instead of by those properties. The assertions also assume that request inputs are stable around the rising edge. The stimulus changes them only at the falling edge and lowers csr_valid right after each accepted edge. Every operation code on the port has a defined meaning, so the bench drives only those eight codes and makes no assumption about illegal encodings.

// File: rtl/vlcsr_pkg.sv
`timescale 1ns/1ps
package vlcsr_pkg;

    localparam int XLEN   = 64;
    localparam int LEN_W  = $clog2(XLEN);
    localparam int TLEN_W = LEN_W + 1;
    localparam int IMM_W  = 5;
    localparam int ADDR_W = 12;
    localparam int N_TGT  = 3;

    localparam int T_VL    = 0;
    localparam int T_MVL   = 1;
    localparam int T_STATE = 2;

    localparam logic [ADDR_W-1:0] ADDR_STATE = 12'h7C0;
    localparam logic [ADDR_W-1:0] ADDR_VL    = 12'h7C1;
    localparam logic [ADDR_W-1:0] ADDR_MVL   = 12'h7C2;

    typedef enum logic [2:0] {
        OP_READ = 3'b000,
        OP_RW   = 3'b001,
        OP_RS   = 3'b010,
        OP_RC   = 3'b011,
        OP_RDI  = 3'b100,
        OP_RWI  = 3'b101,
        OP_RSI  = 3'b110,
        OP_RCI  = 3'b111
    } csr_op_e;

    typedef logic [LEN_W-1:0]  blen_t;
    typedef logic [TLEN_W-1:0] tlen_t;
    typedef logic [XLEN-1:0]   word_t;

    typedef struct packed {
        blen_t mvl;
        blen_t vl;
    } state_t;

    localparam tlen_t MAX_LEN = tlen_t'(XLEN);

    function automatic tlen_t true_len(input blen_t b);
        return {1'b0, b} + tlen_t'(1);
    endfunction

    // Clamp a requested true length into 1..lim, returned in biased form.
    function automatic blen_t clamp_len(input word_t v, input tlen_t lim);
        word_t dec;
        tlen_t lim_dec;
        lim_dec = lim - tlen_t'(1);
        dec     = v - word_t'(1);
        if (v == '0)
            return '0;
        else if (v > word_t'(lim))
            return lim_dec[LEN_W-1:0];
        else
            return dec[LEN_W-1:0];
    endfunction

    function automatic logic op_writes(input csr_op_e op);
        return (op != OP_READ) && (op != OP_RDI);
    endfunction

endpackage

// File: rtl/vlcsr_opalu.sv
`timescale 1ns/1ps
module vlcsr_opalu
    import vlcsr_pkg::*;
#(
    parameter bit IMM_BIAS = 1'b1
) (
    input  csr_op_e          op,
    input  word_t            old_val,
    input  word_t            wdata,
    input  logic [IMM_W-1:0] imm,
    output word_t            next_val
);

    word_t imm_ext;
    word_t imm_wr;

    assign imm_ext = word_t'(imm);

    generate
        if (IMM_BIAS) begin : g_biased
            assign imm_wr = imm_ext + word_t'(1);
        end else begin : g_raw
            assign imm_wr = imm_ext;
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_RW:   next_val = wdata;
            OP_RS:   next_val = old_val | wdata;
            OP_RC:   next_val = old_val & ~wdata;
            OP_RWI:  next_val = imm_wr;
            OP_RSI:  next_val = old_val | imm_ext;
            OP_RCI:  next_val = old_val & ~imm_ext;
            default: next_val = old_val;
        endcase
    end

endmodule

// File: rtl/vlcsr_len_regs.sv
`timescale 1ns/1ps
module vlcsr_len_regs
    import vlcsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_vl,
    input  logic  wr_mvl,
    input  logic  wr_state,
    input  word_t cand_vl,
    input  word_t cand_mvl,
    input  word_t cand_state,
    output blen_t vl_q,
    output blen_t mvl_q
);

    state_t st_in;
    blen_t  vl_n;
    blen_t  mvl_n;
    blen_t  mvl_clamped;

    assign st_in       = state_t'(cand_state[2*LEN_W-1:0]);
    assign mvl_clamped = clamp_len(cand_mvl, MAX_LEN);

    always_comb begin
        vl_n  = vl_q;
        mvl_n = mvl_q;
        if (wr_state) begin
            mvl_n = st_in.mvl;
            vl_n  = (st_in.vl > st_in.mvl) ? st_in.mvl : st_in.vl;
        end else if (wr_mvl) begin
            mvl_n = mvl_clamped;
            vl_n  = (vl_q > mvl_clamped) ? mvl_clamped : vl_q;
        end else if (wr_vl) begin
            vl_n  = clamp_len(cand_vl, true_len(mvl_q));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q  <= '0;
            mvl_q <= '0;
        end else begin
            vl_q  <= vl_n;
            mvl_q <= mvl_n;
        end
    end

    // R9: the active length never passes the maximum
    a_r9_vl_within_mvl: assert property (@(posedge clk) disable iff (rst)
        vl_q <= mvl_q);

    // R8: with no write strobe the stored lengths stay put
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !(wr_vl || wr_mvl || wr_state) |=> ($stable(vl_q) && $stable(mvl_q)));

    // R5: an oversize maximum is capped at the register width
    a_r5_mvl_cap: assert property (@(posedge clk) disable iff (rst)
        (wr_mvl && !wr_state && cand_mvl > word_t'(XLEN)) |=> (mvl_q == blen_t'(XLEN - 1)));

endmodule

// File: rtl/vlcsr_unit.sv
`timescale 1ns/1ps
module vlcsr_unit
    import vlcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_valid,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [2:0]        csr_op,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [IMM_W-1:0]  csr_imm,
    output logic [XLEN-1:0]   csr_rdata,
    output logic [TLEN_W-1:0] vl_len,
    output logic [TLEN_W-1:0] mvl_len
);

    localparam logic [ADDR_W-1:0] TGT_ADDR [N_TGT] = '{ADDR_VL, ADDR_MVL, ADDR_STATE};

    csr_op_e          op;
    logic             wr;
    logic [N_TGT-1:0] hit;
    word_t            old_v  [N_TGT];
    word_t            next_v [N_TGT];
    blen_t            vl_q;
    blen_t            mvl_q;

    assign op = csr_op_e'(csr_op);
    assign wr = op_writes(op);

    assign old_v[T_VL]    = word_t'(true_len(vl_q));
    assign old_v[T_MVL]   = word_t'(true_len(mvl_q));
    assign old_v[T_STATE] = word_t'(state_t'{mvl: mvl_q, vl: vl_q});

    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
        assign hit[g] = csr_valid && (csr_addr == TGT_ADDR[g]);

        vlcsr_opalu #(
            .IMM_BIAS (g != T_STATE)
        ) u_alu (
            .op       (op),
            .old_val  (old_v[g]),
            .wdata    (csr_wdata),
            .imm      (csr_imm),
            .next_val (next_v[g])
        );
    end

    vlcsr_len_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_vl      (hit[T_VL] && wr),
        .wr_mvl     (hit[T_MVL] && wr),
        .wr_state   (hit[T_STATE] && wr),
        .cand_vl    (next_v[T_VL]),
        .cand_mvl   (next_v[T_MVL]),
        .cand_state (next_v[T_STATE]),
        .vl_q       (vl_q),
        .mvl_q      (mvl_q)
    );

    always_comb begin
        csr_rdata = '0;
        for (int t = 0; t < N_TGT; t++) begin
            if (hit[t]) csr_rdata = old_v[t];
        end
    end

    assign vl_len  = true_len(vl_q);
    assign mvl_len = true_len(mvl_q);

    // R4: an in-range VL write lands exactly
    a_r4_vl_write_exact: assert property (@(posedge clk) disable iff (rst)
        (csr_valid && csr_addr == ADDR_VL && csr_op == 3'b001 &&
         csr_wdata != '0 && csr_wdata <= word_t'(mvl_len))
        |=> (word_t'(vl_len) == $past(csr_wdata)));

    // R5: an in-range MVL write lands exactly
    a_r5_mvl_write_exact: assert property (@(posedge clk) disable iff (rst)
        (csr_valid && csr_addr == ADDR_MVL && csr_op == 3'b001 &&
         csr_wdata != '0 && csr_wdata <= word_t'(XLEN))
        |=> (word_t'(mvl_len) == $past(csr_wdata)));

    // R8: an unknown address reads zero and leaves both lengths alone
    a_r8_unknown_addr: assert property (@(posedge clk) disable iff (rst)
        (csr_valid && csr_addr != ADDR_VL && csr_addr != ADDR_MVL && csr_addr != ADDR_STATE)
        |-> (csr_rdata == '0) ##1 ($stable(vl_len) && $stable(mvl_len)));

    // R2: outputs stay within 1..XLEN
    a_r2_len_range: assert property (@(posedge clk) disable iff (rst)
        (vl_len != '0) && (mvl_len != '0) && (mvl_len <= MAX_LEN));

endmodule

// File: tb/test_vlcsr_unit.sv
`timescale 1ns/1ps
module test_vlcsr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_valid = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [2:0]  csr_op = '0;
    logic [63:0] csr_wdata = '0;
    logic [4:0]  csr_imm = '0;
    logic [63:0] csr_rdata;
    logic [6:0]  vl_len;
    logic [6:0]  mvl_len;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [11:0] A_ST  = 12'h7C0;
    localparam logic [11:0] A_VL  = 12'h7C1;
    localparam logic [11:0] A_MVL = 12'h7C2;

    always #2.5 clk = ~clk;

    vlcsr_unit i_vlcsr_unit (
        .clk       (clk),
        .rst       (rst),
        .csr_valid (csr_valid),
        .csr_addr  (csr_addr),
        .csr_op    (csr_op),
        .csr_wdata (csr_wdata),
        .csr_imm   (csr_imm),
        .csr_rdata (csr_rdata),
        .vl_len    (vl_len),
        .mvl_len   (mvl_len)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic access(input logic [11:0] a, input logic [2:0] o, input logic [63:0] w,
                          input logic [4:0] im, output logic [63:0] rd);
        @(negedge clk);
        csr_valid = 1'b1;
        csr_addr  = a;
        csr_op    = o;
        csr_wdata = w;
        csr_imm   = im;
        #1 rd = csr_rdata;
        @(posedge clk);
        #1 csr_valid = 1'b0;
        csr_op = 3'b000;
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] w);
        logic [63:0] rd;
        access(a, 3'b001, w, 5'd0, rd);
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [63:0] exp);
        logic [63:0] rd;
        access(a, 3'b000, 64'd0, 5'd0, rd);
        check(tag, rd, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 VL after reset", A_VL, 64'd1);
        rd_chk("R1 MVL after reset", A_MVL, 64'd1);
        rd_chk("R1 STATE after reset", A_ST, 64'd0);
        check("R1 vl_len port after reset", 64'(vl_len), 64'd1);
    endtask

    task automatic t_mvl();
        logic [63:0] rd;
        access(A_MVL, 3'b001, 64'd64, 5'd0, rd);
        check("R2 MVL write returns old value", rd, 64'd1);
        rd_chk("R2 MVL new value next cycle", A_MVL, 64'd64);
        wr(A_MVL, 64'd100);
        rd_chk("R5 MVL above 64 capped", A_MVL, 64'd64);
        wr(A_MVL, 64'd0);
        rd_chk("R5 MVL zero becomes 1", A_MVL, 64'd1);
        check("R5 mvl_len port", 64'(mvl_len), 64'd1);
        wr(A_MVL, 64'd64);
    endtask

    task automatic t_vl();
        logic [63:0] rd;
        access(A_VL, 3'b001, 64'd10, 5'd0, rd);
        check("R2 VL write returns old value", rd, 64'd1);
        rd_chk("R4 VL in-range write", A_VL, 64'd10);
        wr(A_VL, 64'd0);
        rd_chk("R4 VL zero becomes 1", A_VL, 64'd1);
        wr(A_MVL, 64'd16);
        wr(A_VL, 64'd40);
        rd_chk("R4 VL above MVL clamped", A_VL, 64'd16);
        wr(A_MVL, 64'd8);
        rd_chk("R5 VL lowered by MVL write", A_VL, 64'd8);
        check("R9 vl_len not above mvl_len", 64'(vl_len <= mvl_len), 64'd1);
        wr(A_MVL, 64'd64);
        rd_chk("R5 VL unchanged when MVL raised", A_VL, 64'd8);
    endtask

    task automatic t_imm();
        logic [63:0] rd;
        access(A_MVL, 3'b101, 64'd0, 5'd31, rd);
        rd_chk("R6 MVL immediate 31 gives 32", A_MVL, 64'd32);
        access(A_VL, 3'b101, 64'd0, 5'd4, rd);
        rd_chk("R6 VL immediate 4 gives 5", A_VL, 64'd5);
        access(A_VL, 3'b101, 64'd0, 5'd31, rd);
        rd_chk("R6 VL immediate 31 gives 32", A_VL, 64'd32);
    endtask

    task automatic t_bits();
        logic [63:0] rd;
        wr(A_MVL, 64'd64);
        wr(A_VL, 64'd8);
        access(A_VL, 3'b010, 64'd3, 5'd0, rd);
        check("R7 set-bits returns old", rd, 64'd8);
        rd_chk("R7 VL set bits 8|3", A_VL, 64'd11);
        access(A_VL, 3'b011, 64'd1, 5'd0, rd);
        rd_chk("R7 VL clear bit 0", A_VL, 64'd10);
        access(A_VL, 3'b110, 64'd0, 5'd5, rd);
        rd_chk("R7 VL set immediate 10|5", A_VL, 64'd15);
        access(A_VL, 3'b111, 64'd0, 5'd15, rd);
        rd_chk("R7 VL clear to zero clamps to 1", A_VL, 64'd1);
        wr(A_MVL, 64'd32);
        access(A_MVL, 3'b010, 64'd64, 5'd0, rd);
        rd_chk("R7 MVL set bits 32|64 capped", A_MVL, 64'd64);
    endtask

    task automatic t_state();
        logic [63:0] rd;
        wr(A_MVL, 64'd64);
        wr(A_VL, 64'd1);
        rd_chk("R3 STATE packing", A_ST, 64'd4032);
        wr(A_ST, 64'd1223);
        rd_chk("R3 STATE write sets VL", A_VL, 64'd8);
        rd_chk("R3 STATE write sets MVL", A_MVL, 64'd20);
        rd_chk("R3 STATE readback", A_ST, 64'd1223);
        wr(A_ST, 64'd606);
        rd_chk("R3 STATE MVL field", A_MVL, 64'd10);
        rd_chk("R9 STATE VL field clamped to MVL", A_VL, 64'd10);
        access(A_ST, 3'b101, 64'd0, 5'd3, rd);
        check("R3 STATE immediate returns old", rd, 64'd585);
        rd_chk("R3 STATE immediate MVL", A_MVL, 64'd1);
        rd_chk("R3 STATE immediate VL", A_VL, 64'd1);
    endtask

    task automatic t_ignore();
        logic [63:0] rd;
        wr(A_MVL, 64'd64);
        wr(A_VL, 64'd12);
        access(12'h123, 3'b001, 64'd5, 5'd0, rd);
        check("R8 unknown address reads 0", rd, 64'd0);
        rd_chk("R8 unknown address keeps VL", A_VL, 64'd12);
        rd_chk("R8 unknown address keeps MVL", A_MVL, 64'd64);
        @(negedge clk);
        csr_valid = 1'b0;
        csr_addr  = A_VL;
        csr_op    = 3'b001;
        csr_wdata = 64'd50;
        @(posedge clk);
        #1 csr_op = 3'b000;
        rd_chk("R8 valid low keeps VL", A_VL, 64'd12);
        access(A_VL, 3'b000, 64'd3, 5'd0, rd);
        check("R8 read-only code returns VL", rd, 64'd12);
        access(A_VL, 3'b100, 64'd0, 5'd7, rd);
        rd_chk("R8 read-only codes keep VL", A_VL, 64'd12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mvl();
        t_vl();
        t_imm();
        t_bits();
        t_state();
        t_ignore();
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule